// File: doc/BRIEF.md
# MSB-Justified Bit Gather/Scatter Unit

This unit moves bits of an operand word `a_i` under the control of a selector word `x_i`. In gather mode (pack), the bits of `a_i` that sit under set selector bits are collected into one contiguous run at the top of the result. They keep their relative order, and every bit below the run is cleared. In scatter mode (unpack), the topmost bits of `a_i` are consumed one after another and placed, from high to low, into the positions where the selector has a one. All other result positions are cleared.

Both directions work from the most significant end, and that is the difference from the usual extract/deposit pair. A caller raises `start_i` for one cycle with the operands and the mode. The result is captured in a register, `done_o` follows one cycle later, and the result then holds until the next start. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_ni` rises.

Top module: `msb_bitpack_unit`

## Requirements
- R1: Pack (op_i = 0) places the selected bits of A, in their original order, from result bit WIDTH-1 downward. All result bits below that run are 0.
- R2: Unpack (op_i = 1) places A[WIDTH-1] in the highest set selector position, A[WIDTH-2] in the next lower set position, and so on. Positions where the selector is 0 read 0.
- R3: A selector of all zeros gives a result of 0 in both modes.
- R4: A selector of all ones returns A unchanged in both modes.
- R5: done_o is 1 in exactly the cycle after a cycle with start_i high, and 0 otherwise. result_o changes only on the edge that samples start_i high.
- R6: op_i = 0 selects pack and op_i = 1 selects unpack. With WIDTH = 16, A = 0xB742 and X = 0x0F53, pack gives 0x7A00 and unpack gives 0x0B13.
- R7: While the block is in reset, result_o is 0 and done_o is 0.
- R8: After a pack, the number of ones in result_o equals the number of ones in (A & X).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to compute |
| op_i | input | 1 | Mode: 0 pack, 1 unpack |
| a_i | input | WIDTH | Source operand |
| x_i | input | WIDTH | Selector mask |
| result_o | output | WIDTH | Registered result |
| done_o | output | 1 | High one cycle after start_i |

## Verification
The bench builds two copies of the unit. The first uses the default WIDTH of 48 and takes random operands with dense, sparse and uniform masks, plus the all-zero and all-ones masks. The second uses WIDTH = 16, which lets the known worked example be checked bit for bit. The narrow width also makes masks with very few or nearly all bits set common under random stimulus, which brings the edge ranks of the prefix count within reach. Between requests the operands are scrambled, which exposes any result that changes without a start.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic {
    OP_PACK   = 1'b0,
    OP_UNPACK = 1'b1
  } op_e;
endpackage

// File: rtl/bpu_rst_sync.sv
module bpu_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/bpu_rank.sv
// For every bit position, counts the selector ones strictly above it.
module bpu_rank #(
  parameter int WIDTH = 48,
  localparam int RW = $clog2(WIDTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [WIDTH-1:0]          mask_i,
  output logic [WIDTH-1:0][RW-1:0]  rank_o
);
  assign rank_o[WIDTH-1] = '0;

  genvar gi;
  generate
    for (gi = WIDTH - 2; gi >= 0; gi--) begin : g_chain
      assign rank_o[gi] = rank_o[gi+1] + RW'(mask_i[gi+1]);
    end
  endgenerate

  // R1
  rank_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rank_o[0]) + int'(mask_i[0])) == $countones(mask_i));
endmodule

// File: rtl/bpu_gather.sv
module bpu_gather #(
  parameter int WIDTH = 48,
  localparam int RW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]          a_i,
  input  logic [WIDTH-1:0]          mask_i,
  input  logic [WIDTH-1:0][RW-1:0]  rank_i,
  output logic [WIDTH-1:0]          res_o
);
  always_comb begin
    res_o = '0;
    for (int j = 0; j < WIDTH; j++) begin
      for (int i = 0; i < WIDTH; i++) begin
        if (mask_i[i] && (int'(rank_i[i]) == (WIDTH - 1 - j)))
          res_o[j] = res_o[j] | a_i[i];
      end
    end
  end
endmodule

// File: rtl/bpu_scatter.sv
module bpu_scatter #(
  parameter int WIDTH = 48,
  localparam int RW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]          a_i,
  input  logic [WIDTH-1:0]          mask_i,
  input  logic [WIDTH-1:0][RW-1:0]  rank_i,
  output logic [WIDTH-1:0]          res_o
);
  always_comb begin
    res_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      for (int k = 0; k < WIDTH; k++) begin
        if (mask_i[i] && (int'(rank_i[i]) == k))
          res_o[i] = a_i[WIDTH-1-k];
      end
    end
  end
endmodule

// File: rtl/msb_bitpack_unit.sv
module msb_bitpack_unit #(
  parameter int WIDTH = 48,
  localparam int RW = $clog2(WIDTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  import bpu_pkg::*;

  logic                     rst_sync_n;
  logic [WIDTH-1:0][RW-1:0] rank;
  logic [WIDTH-1:0]         pack_res;
  logic [WIDTH-1:0]         unpack_res;
  logic [WIDTH-1:0]         result_d, result_q;
  logic                     done_d, done_q;
  logic                     result_en;
  op_e                      op;

  assign op = op_e'(op_i);

  bpu_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  bpu_rank #(.WIDTH(WIDTH)) u_rank (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .mask_i (x_i),
    .rank_o (rank)
  );

  bpu_gather #(.WIDTH(WIDTH)) u_gather (
    .a_i    (a_i),
    .mask_i (x_i),
    .rank_i (rank),
    .res_o  (pack_res)
  );

  bpu_scatter #(.WIDTH(WIDTH)) u_scatter (
    .a_i    (a_i),
    .mask_i (x_i),
    .rank_i (rank),
    .res_o  (unpack_res)
  );

  assign result_en = start_i;

  always_comb begin
    result_d = result_q;
    if (result_en)
      result_d = (op == OP_PACK) ? pack_res : unpack_res;
    done_d = start_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (result_en) result_q <= result_d;
      done_q <= done_d;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  // R5
  done_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    start_i |=> done_o);
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !start_i |=> !done_o);
  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !start_i |=> $stable(result_o));
  // R1
  pack_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (start_i && !op_i) |=> ((result_o << $countones($past(x_i))) == '0));
  // R8
  pack_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (start_i && !op_i) |=> ($countones(result_o) == $countones($past(a_i & x_i))));
  // R2
  unpack_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (start_i && op_i) |=> ((result_o & ~$past(x_i)) == '0));
  // R3
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (start_i && (x_i == '0)) |=> (result_o == '0));
  // R4
  full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (start_i && (x_i == '1)) |=> (result_o == $past(a_i)));
endmodule

// File: tb/msb_bitpack_unit_bench.sv
`timescale 1ns/1ps
module msb_bitpack_unit_bench;
  localparam int W  = 48;
  localparam int WS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_a, op_a, done_a;
  logic [W-1:0]  a_a, x_a, res_a;
  logic          start_b, op_b, done_b;
  logic [WS-1:0] a_b, x_b, res_b;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  msb_bitpack_unit #(.WIDTH(W)) u_msb_bitpack_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .op_i(op_a),
    .a_i(a_a), .x_i(x_a), .result_o(res_a), .done_o(done_a));

  msb_bitpack_unit #(.WIDTH(WS)) u_msb_bitpack_unit_w16 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .op_i(op_b),
    .a_i(a_b), .x_i(x_b), .result_o(res_b), .done_o(done_b));

  function automatic logic [W-1:0] model(input logic op, input logic [W-1:0] a,
                                         input logic [W-1:0] x, input int w);
    logic [W-1:0] r = '0;
    int k = w - 1;
    for (int i = w - 1; i >= 0; i--) begin
      if (x[i]) begin
        if (!op) r[k] = a[i];
        else     r[i] = a[k];
        k--;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_a(input logic op, input logic [W-1:0] a, input logic [W-1:0] x,
                       input string req);
    logic [W-1:0] prev;
    @(negedge clk);
    check("R5 idle done", {47'd0, done_a}, '0);
    prev = res_a;
    start_a = 1'b1; op_a = op; a_a = a; x_a = x;
    @(negedge clk);
    check("R5 done", {47'd0, done_a}, 48'd1);
    check(req, res_a, model(op, a, x, W));
    start_a = 1'b0;
    a_a = {$urandom, $urandom} ; x_a = {$urandom, $urandom}; op_a = ~op;
    @(negedge clk);
    check("R5 hold", res_a, model(op, a, x, W));
    if (prev === 'x) check("R5", '0, '0);
  endtask

  task automatic run_b(input logic op, input logic [WS-1:0] a, input logic [WS-1:0] x,
                       input logic [WS-1:0] exp, input string req);
    @(negedge clk);
    start_b = 1'b1; op_b = op; a_b = a; x_b = x;
    @(negedge clk);
    check(req, {32'd0, res_b}, {32'd0, exp});
    check("R5 done w16", {47'd0, done_b}, 48'd1);
    start_b = 1'b0;
    a_b = 16'(~a);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] a, x;
    logic op;
    void'($urandom(32'd1957));
    start_a = 0; op_a = 0; a_a = '0; x_a = '0;
    start_b = 0; op_b = 0; a_b = '0; x_b = '0;
    repeat (3) @(negedge clk);
    // R7
    check("R7 result", res_a, '0);
    check("R7 done", {47'd0, done_a}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 result after release", res_a, '0);

    // R6 worked example, both modes
    run_b(1'b0, 16'hB742, 16'h0F53, 16'h7A00, "R6 R1 pack example");
    run_b(1'b1, 16'hB742, 16'h0F53, 16'h0B13, "R6 R2 unpack example");
    // R3
    run_a(1'b0, 48'hFFFF_FFFF_FFFF, '0, "R3 pack zero mask");
    run_a(1'b1, 48'hFFFF_FFFF_FFFF, '0, "R3 unpack zero mask");
    // R4
    run_a(1'b0, 48'hA5C3_0F96_1234, '1, "R4 pack full mask");
    run_a(1'b1, 48'hA5C3_0F96_1234, '1, "R4 unpack full mask");
    // R1 single low bit goes to the top; R2 top bit goes to single low bit
    run_a(1'b0, 48'h0000_0000_0001, 48'h0000_0000_0001, "R1 pack lsb");
    run_a(1'b1, 48'h8000_0000_0000, 48'h0000_0000_0001, "R2 unpack to lsb");

    for (int n = 0; n < 3000; n++) begin
      a  = {$urandom, $urandom};
      case (n % 3)
        0: x = {$urandom, $urandom};
        1: x = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        default: x = {$urandom, $urandom} | {$urandom, $urandom};
      endcase
      op = n[0] ^ n[3];
      run_a(op, a, x, op ? "R2 R6 unpack random" : "R1 R8 R6 pack random");
      if (n % 4 == 0) begin
        logic [WS-1:0] as, xs;
        as = 16'($urandom); xs = 16'($urandom) & 16'($urandom);
        run_b(op, as, xs, 16'(model(op, {32'd0, as}, {32'd0, xs}, WS)),
              op ? "R2 unpack w16" : "R1 pack w16");
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule